// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple request/ready port and an asynchronous 64K x 16 DRAM. The DRAM has an 8-bit multiplexed address bus, one row strobe and separate strobes for the low and high byte lanes. A request carries a 16-bit word address, two byte enables, a write flag and 16 bits of write data. The controller splits the address into an 8-bit row (upper half) and an 8-bit column (lower half). It opens the row with the row strobe and then runs one column cycle with the byte strobes that the enables select.

The row stays open after the access. A later request to the same row costs only another column cycle. A request to a different row, a refresh request, or the end of the allowed page time closes the row. The controller then waits out the precharge before it starts anything new. Refresh requests arrive on a request/acknowledge pair. The controller serves each one with a refresh cycle in which the column strobes fall before the row strobe.

Every interval is a parameter counted in system clocks: the row-to-column delay, column pulse width, column precharge, row precharge, minimum row-low time and maximum page time. Reads sample the bus at the last clock of the column pulse. Writes are always early writes.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and right after it, the row strobe, both column strobes, write enable and output enable are high, the data bus is not driven, and `req_ready` and `ref_ack` are low.
- R2: The row address `req_addr[15:8]` is on `dram_addr` when the row strobe falls, and the column address `req_addr[7:0]` is on `dram_addr` when a column strobe falls.
- R3: `dram_lcas_n` (data bits 7:0) falls only if `req_be[0]` is set, and `dram_ucas_n` (data bits 15:8) falls only if `req_be[1]` is set.
- R4: In a write, write enable is low and the write data is driven for at least one clock before a column strobe falls. The enabled bytes are stored at the addressed word.
- R5: In a read, write enable stays high and output enable is low. The bus is sampled on the last clock of the column pulse and returned on `rsp_rdata`, with lanes whose byte enable is clear read as zero.
- R6: Each request completes with `req_ready` high for exactly one clock, and a read's data is valid in that clock.
- R7: A request whose row equals the open row is served by a column cycle alone, with no new row activation.
- R8: A request to a different row raises the row strobe, waits the precharge, and then activates the new row.
- R9: The row strobe stays low for at least `T_RAS` clocks and high for at least `T_RP` clocks between low periods. At least `T_RCD+1` clocks of row-low precede the first column strobe fall of a row.
- R10: Each column pulse lasts at least `T_CAS` clocks. Within an open row, the column strobes stay high for at least `T_CP` clocks between pulses.
- R11: The row strobe never stays low for more than `T_PAGE` clocks, and an open row that is left idle is closed on its own.
- R12: On `ref_req`, the controller closes any open row (once the minimum row-low time is met). It then drops both column strobes one clock before the row strobe, holds the row strobe low for `T_RAS` clocks with no bus drive and output enable high, and pulses `ref_ack`. A pending refresh is served before a pending access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address, row in bits 15:8, column in bits 7:0 |
| req_be | input | 2 | Byte enables, bit 0 = data 7:0, bit 1 = data 15:8 |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `req_ready` |
| ref_req | input | 1 | Refresh wanted; held until `ref_ack` |
| ref_ack | output | 1 | One-clock pulse at the end of a refresh cycle |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Low-byte column strobe, active low |
| dram_ucas_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
A refresh request and an access to the already-open row can be pending in the same clock, and the controller must pick one. The bench provokes this by raising `ref_req` and a same-row read on the same clock edge. It then judges the result at the ports. `ref_ack` must come before `req_ready`. Exactly one refresh cycle and exactly one new row activation must be seen on the DRAM pins, and the read must still return the stored word.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 3,
  parameter int T_CP   = 1,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 6,
  parameter int T_PAGE = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [1:0]  req_be,
  input  logic [15:0] req_wdata,
  output logic        req_ready,
  output logic [15:0] rsp_rdata,
  input  logic        ref_req,
  output logic        ref_ack,
  output logic [7:0]  dram_addr,
  output logic        dram_ras_n,
  output logic        dram_lcas_n,
  output logic        dram_ucas_n,
  output logic        dram_we_n,
  output logic        dram_oe_n,
  output logic [15:0] dram_dq_out,
  output logic        dram_dq_oe,
  input  logic [15:0] dram_dq_in
);

  localparam int CW       = $clog2(T_PAGE + 1);
  localparam int PAGE_LIM = T_PAGE - T_CAS - 2;

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_COL, S_CAS, S_OPEN, S_PRE, S_CBR_SET, S_CBR} st_t;

  st_t           st;
  logic [CW-1:0] cnt, ras_cnt, hi_cnt;
  logic [7:0]    row_q, col_q;
  logic [1:0]    be_q;
  logic          wr_q;

  logic hit, cp_ok, ras_ok, page_end, want_close;
  assign hit        = req_addr[15:8] == row_q;
  assign cp_ok      = cnt >= CW'(T_CP);
  assign ras_ok     = ras_cnt >= CW'(T_RAS - 1);
  assign page_end   = ras_cnt >= CW'(PAGE_LIM);
  assign want_close = ref_req || page_end || (req_valid && !hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ras_cnt <= '0;
      row_q <= '0;
      col_q <= '0;
      be_q <= '0;
      wr_q <= 1'b0;
      req_ready <= 1'b0;
      rsp_rdata <= '0;
      ref_ack <= 1'b0;
      dram_addr <= '0;
      dram_ras_n <= 1'b1;
      dram_lcas_n <= 1'b1;
      dram_ucas_n <= 1'b1;
      dram_we_n <= 1'b1;
      dram_oe_n <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe <= 1'b0;
    end else begin
      req_ready <= 1'b0;
      ref_ack <= 1'b0;
      ras_cnt <= dram_ras_n ? '0 : ras_cnt + 1'b1;
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          if (ref_req) begin
            dram_lcas_n <= 1'b0;
            dram_ucas_n <= 1'b0;
            st <= S_CBR_SET;
            cnt <= '0;
          end else if (req_valid) begin
            row_q <= req_addr[15:8];
            col_q <= req_addr[7:0];
            be_q <= req_be;
            wr_q <= req_write;
            dram_dq_out <= req_wdata;
            dram_addr <= req_addr[15:8];
            dram_ras_n <= 1'b0;
            st <= S_RCD;
            cnt <= '0;
          end
        end
        S_RCD: begin
          if (cnt == CW'(T_RCD - 1)) begin
            dram_addr <= col_q;
            dram_we_n <= !wr_q;
            dram_oe_n <= wr_q;
            dram_dq_oe <= wr_q;
            st <= S_COL;
            cnt <= '0;
          end
        end
        S_COL: begin
          dram_lcas_n <= !be_q[0];
          dram_ucas_n <= !be_q[1];
          st <= S_CAS;
          cnt <= '0;
        end
        S_CAS: begin
          if (cnt == CW'(T_CAS - 1)) begin
            dram_lcas_n <= 1'b1;
            dram_ucas_n <= 1'b1;
            dram_we_n <= 1'b1;
            dram_oe_n <= 1'b1;
            dram_dq_oe <= 1'b0;
            req_ready <= 1'b1;
            if (!wr_q) rsp_rdata <= dram_dq_in & {{8{be_q[1]}}, {8{be_q[0]}}};
            st <= S_OPEN;
            cnt <= '0;
          end
        end
        S_OPEN: begin
          if (want_close) begin
            if (ras_ok) begin
              dram_ras_n <= 1'b1;
              st <= S_PRE;
              cnt <= '0;
            end
          end else if (req_valid && cp_ok) begin
            col_q <= req_addr[7:0];
            be_q <= req_be;
            wr_q <= req_write;
            dram_addr <= req_addr[7:0];
            dram_we_n <= !req_write;
            dram_oe_n <= req_write;
            dram_dq_oe <= req_write;
            dram_dq_out <= req_wdata;
            st <= S_COL;
            cnt <= '0;
          end
        end
        S_PRE: begin
          if (cnt == CW'(T_RP - 1)) st <= S_IDLE;
        end
        S_CBR_SET: begin
          dram_ras_n <= 1'b0;
          st <= S_CBR;
          cnt <= '0;
        end
        S_CBR: begin
          if (cnt == CW'(T_RAS - 1)) begin
            dram_ras_n <= 1'b1;
            dram_lcas_n <= 1'b1;
            dram_ucas_n <= 1'b1;
            ref_ack <= 1'b1;
            st <= S_PRE;
            cnt <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= CW'(T_RP);
    else if (!dram_ras_n) hi_cnt <= '0;
    else if (hi_cnt < CW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> $past(ras_cnt) >= CW'(T_RAS - 1)); // R9
  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $past(hi_cnt) >= CW'(T_RP - 1)); // R9
  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> ras_cnt < CW'(T_PAGE)); // R11
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_ras_n && !dram_we_n)
      |-> (!$past(dram_we_n) && $past(dram_dq_oe))); // R4
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_lcas_n)
      |-> (!$past(dram_lcas_n) && !$past(dram_ucas_n) && dram_oe_n && !dram_dq_oe)); // R12
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R6

endmodule

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
  localparam int T_RCD = 2, T_CAS = 3, T_CP = 1, T_RP = 3, T_RAS = 6, T_PAGE = 1000;
  localparam int NV = 11;
  // {wr, be[1:0], addr[15:0], wdata[15:0], exp_rdata[15:0], exp_activation}
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 2'b11, 16'h0312, 16'h1234, 16'h0000, 1'b1},
    {1'b1, 2'b11, 16'h0305, 16'hBEEF, 16'h0000, 1'b0},
    {1'b0, 2'b11, 16'h0312, 16'h0000, 16'h1234, 1'b0},
    {1'b1, 2'b01, 16'h0312, 16'h00AB, 16'h0000, 1'b0},
    {1'b1, 2'b10, 16'h0305, 16'h5A00, 16'h0000, 1'b0},
    {1'b0, 2'b11, 16'h0312, 16'h0000, 16'h12AB, 1'b0},
    {1'b0, 2'b10, 16'h0305, 16'h0000, 16'h5A00, 1'b0},
    {1'b1, 2'b11, 16'h0712, 16'hCAFE, 16'h0000, 1'b1},
    {1'b0, 2'b01, 16'h0312, 16'h0000, 16'h00AB, 1'b1},
    {1'b0, 2'b11, 16'h0712, 16'h0000, 16'hCAFE, 1'b1},
    {1'b0, 2'b11, 16'h0305, 16'h0000, 16'h5AEF, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, ref_ack, dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] rsp_rdata, dram_dq_out, dram_dq_in;
  logic [7:0] dram_addr;

  int n_chk = 0, n_fail = 0;
  always #5 clk = ~clk;

  fpm_dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                  .T_RAS(T_RAS), .T_PAGE(T_PAGE)) u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_ack(ref_ack), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // DRAM pin model: watches the values held during each clock period
  logic [15:0] mem [256];
  logic [7:0] row_l = '0, col_l = '0;
  logic pr = 1'b1, pl = 1'b1, pu = 1'b1, pw = 1'b1, pdq = 1'b0;
  int lo_len = 0, hi_len = 100, cas_lo = 0, cas_hi = 100, act_cnt = 0, cbr_cnt = 0;
  bit first_cas = 1'b0, in_cbr = 1'b0, l_fell = 1'b0, u_fell = 1'b0;
  logic [7:0] rd_idx;
  assign rd_idx = {row_l[3:0], col_l[3:0]};
  assign dram_dq_in = {(!dram_ucas_n && !dram_oe_n && dram_we_n) ? mem[rd_idx][15:8] : 8'hA5,
                       (!dram_lcas_n && !dram_oe_n && dram_we_n) ? mem[rd_idx][7:0]  : 8'hA5};

  always @(posedge clk) begin
    if (rst_n) begin
      if (pr && !dram_ras_n) begin
        chk(hi_len >= T_RP, "R9 row precharge", hi_len, T_RP);
        lo_len = 1;
        row_l = dram_addr;
        first_cas = 1'b1;
        if (!dram_lcas_n && !dram_ucas_n) begin
          cbr_cnt++;
          in_cbr = 1'b1;
          chk(!pl && !pu && dram_oe_n && !dram_dq_oe, "R12 refresh strobe order", {pl, pu, dram_oe_n, dram_dq_oe}, 4'b0010);
        end else begin
          act_cnt++;
          in_cbr = 1'b0;
        end
      end else if (!dram_ras_n) lo_len++;
      if (!pr && dram_ras_n) begin
        chk(lo_len >= T_RAS, "R9 row low width", lo_len, T_RAS);
        chk(lo_len <= T_PAGE, "R11 page time", lo_len, T_PAGE);
        hi_len = 1;
      end else if (dram_ras_n) hi_len++;
      if ((!dram_lcas_n || !dram_ucas_n) && pl && pu && !dram_ras_n && !in_cbr) begin
        if (first_cas) chk(lo_len - 1 >= T_RCD + 1, "R9 row to column delay", lo_len - 1, T_RCD + 1);
        else chk(cas_hi >= T_CP, "R10 column precharge", cas_hi, T_CP);
        first_cas = 1'b0;
        col_l = dram_addr;
        l_fell = !dram_lcas_n;
        u_fell = !dram_ucas_n;
        cas_lo = 1;
        if (!dram_we_n) begin
          chk(!pw && pdq, "R4 early write setup", {pw, pdq}, 2'b01);
          if (!dram_lcas_n) mem[{row_l[3:0], dram_addr[3:0]}][7:0] = dram_dq_out[7:0];
          if (!dram_ucas_n) mem[{row_l[3:0], dram_addr[3:0]}][15:8] = dram_dq_out[15:8];
        end
      end else if ((!dram_lcas_n || !dram_ucas_n) && !dram_ras_n) cas_lo++;
      if (dram_lcas_n && dram_ucas_n && (!pl || !pu) && !dram_ras_n && !in_cbr) begin
        chk(cas_lo >= T_CAS, "R10 column pulse width", cas_lo, T_CAS);
        cas_hi = 1;
      end else if (dram_lcas_n && dram_ucas_n) cas_hi++;
      pr = dram_ras_n; pl = dram_lcas_n; pu = dram_ucas_n; pw = dram_we_n; pdq = dram_dq_oe;
    end
  end

  task automatic do_req(input logic wr, input logic [1:0] be, input logic [15:0] addr,
                        input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = addr; req_wdata = wd;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    rd = rsp_rdata;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R6 ready single pulse", req_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int a0, c0, t_ack, t_rdy;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !req_ready && !ref_ack,
        "R1 reset state", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe, req_ready, ref_ack}, 8'hF8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n && !dram_dq_oe, "R1 state after reset",
        {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_dq_oe}, 4'hE);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VEC[i];
      a0 = act_cnt;
      do_req(v[51], v[50:49], v[48:33], v[32:17], rd);
      if (!v[51]) chk(rd == v[16:1], "R5 read data", rd, v[16:1]);
      if (v[0]) chk(act_cnt - a0 == 1, "R8 new row activation", act_cnt - a0, 1);
      else chk(act_cnt == a0, "R7 page hit without activation", act_cnt - a0, 0);
      chk({u_fell, l_fell} == v[50:49], "R3 byte strobes", {u_fell, l_fell}, v[50:49]);
      chk(row_l == v[48:41] && col_l == v[40:33], "R2 row and column address", {row_l, col_l}, v[48:33]);
    end

    do_req(1'b1, 2'b11, 16'h0312, 16'h7777, rd);
    // R12: refresh and a same-row read raised on the same edge
    a0 = act_cnt; c0 = cbr_cnt; t_ack = -1; t_rdy = -1;
    @(negedge clk);
    ref_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_be = 2'b11; req_addr = 16'h0312;
    for (int n = 0; n < 3000 && (t_ack < 0 || t_rdy < 0); n++) begin
      @(negedge clk);
      if (ref_ack) begin t_ack = n; ref_req = 1'b0; end
      if (req_ready) begin t_rdy = n; rd = rsp_rdata; req_valid = 1'b0; end
    end
    chk(t_ack >= 0 && t_ack < t_rdy, "R12 refresh served first", t_ack, t_rdy);
    chk(cbr_cnt - c0 == 1, "R12 one refresh cycle", cbr_cnt - c0, 1);
    chk(act_cnt - a0 == 1, "R8 row reopened after refresh", act_cnt - a0, 1);
    chk(rd == 16'h7777, "R5 read after refresh", rd, 16'h7777);

    // R11: an idle open row closes by itself
    for (int n = 0; n < T_PAGE + 20 && !dram_ras_n; n++) @(negedge clk);
    chk(dram_ras_n, "R11 idle row closed", dram_ras_n, 1);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule